// File: doc/BRIEF.md
# Low-Power Wake Controller

This block sits beside a small CPU core and governs its two low-power states. The CPU asks for a light stop (halt) or a deep stop (sleep). While stopped, the CPU clock enable is held low. The controller watches three groups of wake sources: I/O port events together with a debug forced-break, interrupts from the slow-oscillator timers, and interrupts from peripherals clocked by the peripheral clock. The set of sources that may end the stop depends on which state is active.

When a stop ends, the controller sends the CPU a single resume pulse. It then decides whether the CPU continues at the next instruction or takes an interrupt. The interrupt is taken only when the interrupt controller enables the waking source and the CPU interrupt-enable flag is set. If the peripheral clock was stopped when the CPU entered the low-power state, a permitted interrupt is held pending. Vectoring is then delayed until that clock runs again. The take-interrupt request stays raised until the CPU acknowledges it.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: After reset the CPU clock enable is 1, and resume, take-interrupt and the held flag are all 0.
- R2: A halt or sleep request seen at a clock edge while running drops the CPU clock enable from the next cycle on. If both requests arrive in the same cycle, sleep is entered.
- R3: In sleep, only an I/O port line or the debug break ends the stop. Slow-timer and peripheral-clock interrupts leave the CPU stopped.
- R4: In halt, port lines, the debug break and slow-timer lines all end the stop. A peripheral-clock interrupt ends it only when its mask bit is set and the peripheral clock is running.
- R5: A wake source seen during a stopped cycle raises the clock enable and a one-cycle resume pulse at the next edge. A source already active when the stop begins gives exactly one stopped cycle.
- R6: The waking interrupt is blocked when its mask bit is 0 or the CPU interrupt-enable flag is 0. A blocked interrupt still wakes the CPU but raises neither take-interrupt nor the held flag. The mask bit order is: port lines in bits [N_PORT-1:0], slow-timer lines next, and peripheral-clock lines at the top.
- R7: If the waking interrupt is permitted and the peripheral clock was running at entry, take-interrupt rises together with resume.
- R8: If the waking interrupt is permitted and the peripheral clock was stopped at entry, the held flag rises together with resume and take-interrupt stays 0. Take-interrupt rises at the edge after the peripheral clock is seen running.
- R9: Take-interrupt and the held flag stay set until the acknowledge input is sampled high. Both are 0 from the following cycle.
- R10: The debug break wakes the CPU but never requests an interrupt.
- R11: Halt and sleep requests made while stopped are ignored, and the current stop state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | CPU asks for the light stop |
| sleep_req | input | 1 | CPU asks for the deep stop |
| port_irq | input | N_PORT | I/O port interrupt lines |
| dbg_break | input | 1 | Debug forced-break event |
| slow_irq | input | N_SLOW | Slow-oscillator timer interrupt lines |
| pclk_irq | input | N_PCLK | Peripheral-clock-domain interrupt lines |
| ic_en | input | N_PORT+N_SLOW+N_PCLK | Interrupt controller enable mask |
| cpu_ie | input | 1 | CPU interrupt-enable flag |
| pclk_run | input | 1 | Peripheral clock is running |
| take_ack | input | 1 | CPU accepts the interrupt request |
| cpu_clk_en | output | 1 | CPU clock enable |
| resume | output | 1 | One-cycle pulse when a stop ends |
| take_irq | output | 1 | Request to vector to the handler |
| irq_held | output | 1 | Permitted interrupt waiting for the peripheral clock |

## Verification
The assertions assume that all request, interrupt and status inputs are already synchronous to clk. They also assume that take_ack is raised only while take-interrupt is set, and never in the same cycle as a new wake. The stimulus drives every input on the falling edge. It acknowledges only after the request has been observed, and it clears wake sources before the next stop is requested, except in the scenario that deliberately starts a stop with a source already active.

// File: rtl/lpwr_wake_pkg.sv
package lpwr_wake_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_HALT  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_state_e;

  // Which raw events may end the present stop state.
  function automatic logic wake_allowed(input pm_state_e st, input logic port_any,
                                        input logic dbg, input logic slow_any,
                                        input logic pclk_ok);
    case (st)
      PM_SLEEP: wake_allowed = port_any | dbg;
      PM_HALT:  wake_allowed = port_any | dbg | slow_any | pclk_ok;
      default:  wake_allowed = 1'b0;
    endcase
  endfunction

  // Whether a waking maskable interrupt may be taken.
  function automatic logic grant_ok(input pm_state_e st, input logic port_en,
                                    input logic slow_en, input logic pclk_ok,
                                    input logic ie);
    if (!ie) grant_ok = 1'b0;
    else begin
      case (st)
        PM_SLEEP: grant_ok = port_en;
        PM_HALT:  grant_ok = port_en | slow_en | pclk_ok;
        default:  grant_ok = 1'b0;
      endcase
    end
  endfunction

endpackage

// File: rtl/lpwr_wake_src.sv
module lpwr_wake_src
  import lpwr_wake_pkg::*;
#(
  parameter int N_PORT = 4,
  parameter int N_SLOW = 4,
  parameter int N_PCLK = 8
) (
  input  pm_state_e                  state,
  input  logic [N_PORT-1:0]          port_irq,
  input  logic                       dbg_break,
  input  logic [N_SLOW-1:0]          slow_irq,
  input  logic [N_PCLK-1:0]          pclk_irq,
  input  logic [N_PORT+N_SLOW+N_PCLK-1:0] ic_en,
  input  logic                       cpu_ie,
  input  logic                       pclk_run,
  output logic                       wake_hit,
  output logic                       int_ok
);
  localparam int SLOW_LO = N_PORT;
  localparam int PCLK_LO = N_PORT + N_SLOW;

  logic [N_PORT-1:0] port_en_hit;
  logic [N_SLOW-1:0] slow_en_hit;
  logic [N_PCLK-1:0] pclk_en_hit;
  logic              pclk_ok;

  assign port_en_hit = port_irq & ic_en[N_PORT-1:0];
  assign slow_en_hit = slow_irq & ic_en[SLOW_LO +: N_SLOW];
  assign pclk_en_hit = pclk_irq & ic_en[PCLK_LO +: N_PCLK];
  // Peripheral-clock interrupts exist only while that clock runs.
  assign pclk_ok     = (|pclk_en_hit) & pclk_run;

  assign wake_hit = wake_allowed(state, |port_irq, dbg_break, |slow_irq, pclk_ok);
  assign int_ok   = grant_ok(state, |port_en_hit, |slow_en_hit, pclk_ok, cpu_ie);
endmodule

// File: rtl/lpwr_mode_fsm.sv
module lpwr_mode_fsm
  import lpwr_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      sleep_req,
  input  logic      pclk_run,
  input  logic      wake_hit,
  output pm_state_e state,
  output logic      pclk_was_run,
  output logic      resume_q,
  output logic      wake_fire
);
  assign wake_fire = (state != PM_RUN) & wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= PM_RUN;
      pclk_was_run <= 1'b0;
      resume_q     <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      case (state)
        PM_RUN: begin
          if (sleep_req) begin
            state        <= PM_SLEEP;
            pclk_was_run <= pclk_run;
          end else if (halt_req) begin
            state        <= PM_HALT;
            pclk_was_run <= pclk_run;
          end
        end
        default: begin
          if (wake_hit) begin
            state    <= PM_RUN;
            resume_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lpwr_irq_track.sv
module lpwr_irq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_fire,
  input  logic int_ok,
  input  logic pclk_was_run,
  input  logic pclk_run,
  input  logic take_ack,
  output logic take_q,
  output logic hold_q
);
  logic grant_now, grant_late;

  assign grant_now  = wake_fire & int_ok & pclk_was_run;
  assign grant_late = wake_fire & int_ok & ~pclk_was_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (take_ack) begin
      take_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      take_q <= take_q | grant_now | (hold_q & pclk_run);
      hold_q <= hold_q | grant_late;
    end
  end
endmodule

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl
  import lpwr_wake_pkg::*;
#(
  parameter int N_PORT = 4,
  parameter int N_SLOW = 4,
  parameter int N_PCLK = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            halt_req,
  input  logic                            sleep_req,
  input  logic [N_PORT-1:0]               port_irq,
  input  logic                            dbg_break,
  input  logic [N_SLOW-1:0]               slow_irq,
  input  logic [N_PCLK-1:0]               pclk_irq,
  input  logic [N_PORT+N_SLOW+N_PCLK-1:0] ic_en,
  input  logic                            cpu_ie,
  input  logic                            pclk_run,
  input  logic                            take_ack,
  output logic                            cpu_clk_en,
  output logic                            resume,
  output logic                            take_irq,
  output logic                            irq_held
);
  pm_state_e state;
  logic wake_hit, int_ok, wake_fire, pclk_was_run, resume_q, take_q, hold_q;
  logic in_run, in_sleep;

  lpwr_wake_src #(.N_PORT(N_PORT), .N_SLOW(N_SLOW), .N_PCLK(N_PCLK)) u_src (
    .state(state), .port_irq(port_irq), .dbg_break(dbg_break),
    .slow_irq(slow_irq), .pclk_irq(pclk_irq), .ic_en(ic_en),
    .cpu_ie(cpu_ie), .pclk_run(pclk_run),
    .wake_hit(wake_hit), .int_ok(int_ok)
  );

  lpwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .pclk_run(pclk_run), .wake_hit(wake_hit), .state(state),
    .pclk_was_run(pclk_was_run), .resume_q(resume_q), .wake_fire(wake_fire)
  );

  lpwr_irq_track u_trk (
    .clk(clk), .rst_n(rst_n), .wake_fire(wake_fire), .int_ok(int_ok),
    .pclk_was_run(pclk_was_run), .pclk_run(pclk_run), .take_ack(take_ack),
    .take_q(take_q), .hold_q(hold_q)
  );

  assign in_run     = (state == PM_RUN);
  assign in_sleep   = (state == PM_SLEEP);
  assign cpu_clk_en = in_run;
  assign resume     = resume_q;
  assign take_irq   = take_q;
  assign irq_held   = hold_q;
endmodule

// File: rtl/lpwr_wake_chk.sv
module lpwr_wake_chk #(
  parameter int N_PORT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_run,
  input logic              in_sleep,
  input logic              wake_hit,
  input logic [N_PORT-1:0] port_irq,
  input logic              dbg_break,
  input logic              halt_req,
  input logic              pclk_run,
  input logic              take_ack,
  input logic              cpu_clk_en,
  input logic              resume,
  input logic              take_irq,
  input logic              irq_held
);
  a_r2_enter_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && halt_req |=> !cpu_clk_en);

  a_r3_sleep_sources: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep && !(|port_irq) && !dbg_break |=> !cpu_clk_en);

  a_r11_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run && !wake_hit |=> !cpu_clk_en);

  a_r5_one_cycle_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  a_r5_resume_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> cpu_clk_en && $past(!in_run));

  a_r8_take_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_irq) |-> resume || ($past(irq_held) && $past(pclk_run)));

  a_r9_take_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq && !take_ack |=> take_irq);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_ack |=> !take_irq && !irq_held);
endmodule

bind lpwr_wake_ctrl lpwr_wake_chk #(.N_PORT(N_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_run(in_run), .in_sleep(in_sleep),
  .wake_hit(wake_hit), .port_irq(port_irq), .dbg_break(dbg_break),
  .halt_req(halt_req), .pclk_run(pclk_run), .take_ack(take_ack),
  .cpu_clk_en(cpu_clk_en), .resume(resume), .take_irq(take_irq),
  .irq_held(irq_held)
);

// File: tb/lpwr_wake_ctrl_tb.sv
module lpwr_wake_ctrl_tb;
  localparam int NP = 4, NS = 4, NC = 8, NM = NP + NS + NC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, dbg_break = 0, cpu_ie = 0, pclk_run = 1, take_ack = 0;
  logic [NP-1:0] port_irq = '0;
  logic [NS-1:0] slow_irq = '0;
  logic [NC-1:0] pclk_irq = '0;
  logic [NM-1:0] ic_en = '0;
  logic cpu_clk_en, resume, take_irq, irq_held;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state: 0 running, 1 light stop, 2 deep stop
  int  m_mode = 0;
  bit  m_entry_pclk = 0, m_res = 0, m_take = 0, m_held = 0;

  always #10 clk = ~clk;

  lpwr_wake_ctrl #(.N_PORT(NP), .N_SLOW(NS), .N_PCLK(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .port_irq(port_irq), .dbg_break(dbg_break), .slow_irq(slow_irq),
    .pclk_irq(pclk_irq), .ic_en(ic_en), .cpu_ie(cpu_ie), .pclk_run(pclk_run),
    .take_ack(take_ack), .cpu_clk_en(cpu_clk_en), .resume(resume),
    .take_irq(take_irq), .irq_held(irq_held)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_entry_pclk = 0; m_res = 0; m_take = 0; m_held = 0;
    end else begin
      bit woke, allowed, p_en, s_en, c_ok, old_held;
      old_held = m_held;
      p_en = (port_irq & ic_en[NP-1:0]) != 0;
      s_en = (slow_irq & ic_en[NP+NS-1:NP]) != 0;
      c_ok = ((pclk_irq & ic_en[NM-1:NP+NS]) != 0) && pclk_run;
      woke = 0; allowed = 0;
      if (m_mode == 2) begin
        woke = (port_irq != 0) || dbg_break;
        allowed = cpu_ie && p_en;
      end else if (m_mode == 1) begin
        woke = (port_irq != 0) || dbg_break || (slow_irq != 0) || c_ok;
        allowed = cpu_ie && (p_en || s_en || c_ok);
      end
      m_res = 0;
      if (m_mode == 0) begin
        if (sleep_req || halt_req) begin
          m_mode = sleep_req ? 2 : 1;
          m_entry_pclk = pclk_run;
        end
      end else if (woke) begin
        m_mode = 0;
        m_res = 1;
        if (allowed && m_entry_pclk) m_take = 1;
        if (allowed && !m_entry_pclk) m_held = 1;
      end
      if (old_held && pclk_run) m_take = 1;
      if (take_ack) begin m_take = 0; m_held = 0; end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "model clk_en", int'(cpu_clk_en), int'(m_mode == 0));
      check(cur_req, "model resume", int'(resume), int'(m_res));
      check(cur_req, "model take",   int'(take_irq), int'(m_take));
      check(cur_req, "model held",   int'(irq_held), int'(m_held));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter(bit deep);
    @(negedge clk);
    if (deep) sleep_req = 1; else halt_req = 1;
    @(negedge clk);
    sleep_req = 0; halt_req = 0;
  endtask

  task automatic ack();
    take_ack = 1;
    @(negedge clk);
    take_ack = 0;
  endtask

  task automatic quiet();
    port_irq = '0; slow_irq = '0; pclk_irq = '0; dbg_break = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    check("R1", "reset clk_en", int'(cpu_clk_en), 1);
    check("R1", "reset outputs", int'({resume, take_irq, irq_held}), 0);
    rst_n = 1;
    tick(1);

    // R2/R4/R7/R9: light stop, slow timer wakes, permitted, pclk running
    cur_req = "R2";
    ic_en = '1; cpu_ie = 1; pclk_run = 1;
    enter(0);
    check("R2", "clk_en after halt", int'(cpu_clk_en), 0);
    cur_req = "R4";
    tick(3);
    check("R4", "no source keeps stop", int'(cpu_clk_en), 0);
    slow_irq = 4'b0010;
    @(negedge clk);
    check("R7", "take with resume", int'({cpu_clk_en, resume, take_irq}), 7);
    quiet();
    @(negedge clk);
    check("R5", "resume one cycle", int'(resume), 0);
    cur_req = "R9";
    tick(2);
    check("R9", "take sticky", int'(take_irq), 1);
    ack();
    check("R9", "ack clears", int'(take_irq), 0);

    // R3: deep stop ignores slow and pclk interrupts, port wakes
    cur_req = "R3";
    enter(1);
    slow_irq = 4'b1000; pclk_irq = 8'h81;
    tick(3);
    check("R3", "deep stop ignores timers", int'(cpu_clk_en), 0);
    quiet(); port_irq = 4'b0100;
    @(negedge clk);
    check("R3", "port wakes deep stop", int'({cpu_clk_en, resume}), 3);
    quiet();
    ack();

    // R6: blocked by interrupt-enable flag and by mask
    cur_req = "R6";
    cpu_ie = 0;
    enter(0);
    port_irq = 4'b0001;
    @(negedge clk);
    check("R6", "ie=0 resumes without take", int'({resume, take_irq, irq_held}), 4);
    quiet(); cpu_ie = 1;
    ic_en = '1; ic_en[NP+2] = 0;
    enter(0);
    slow_irq = 4'b0100;
    @(negedge clk);
    check("R6", "masked slow line no take", int'({resume, take_irq, irq_held}), 4);
    quiet(); ic_en = '1;

    // R8: peripheral clock stopped at entry
    cur_req = "R8";
    pclk_run = 0;
    enter(0);
    slow_irq = 4'b0001;
    @(negedge clk);
    check("R8", "held, not taken", int'({resume, take_irq, irq_held}), 5);
    quiet();
    tick(3);
    check("R8", "still waiting", int'(take_irq), 0);
    pclk_run = 1;
    @(negedge clk);
    check("R8", "take after pclk returns", int'({take_irq, irq_held}), 3);
    ack();
    check("R9", "ack clears held", int'({take_irq, irq_held}), 0);

    // R4: pclk-domain interrupt needs running clock and mask bit
    cur_req = "R4";
    enter(0);
    pclk_run = 0; pclk_irq = 8'h10;
    tick(2);
    check("R4", "pclk irq without clock", int'(cpu_clk_en), 0);
    pclk_run = 1; ic_en[NP+NS+4] = 0;
    tick(2);
    check("R4", "pclk irq masked", int'(cpu_clk_en), 0);
    ic_en = '1;
    @(negedge clk);
    check("R4", "pclk irq wakes", int'({cpu_clk_en, resume, take_irq}), 7);
    quiet();
    ack();

    // R10: debug break in deep stop
    cur_req = "R10";
    enter(1);
    dbg_break = 1;
    @(negedge clk);
    check("R10", "debug wakes, no take", int'({resume, take_irq, irq_held}), 4);
    quiet();

    // R11: requests while stopped ignored
    cur_req = "R11";
    enter(0);
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0; halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    check("R11", "still stopped", int'(cpu_clk_en), 0);
    slow_irq = 4'b0001;
    @(negedge clk);
    check("R11", "light stop kept, slow wakes", int'(resume), 1);
    quiet();
    ack();

    // R5: source already active at entry
    cur_req = "R5";
    cpu_ie = 0;
    port_irq = 4'b0010;
    enter(0);
    check("R5", "one stopped cycle", int'(cpu_clk_en), 0);
    @(negedge clk);
    check("R5", "immediate resume", int'({cpu_clk_en, resume}), 3);
    quiet(); cpu_ie = 1;

    // R2: both requests, deep stop wins
    cur_req = "R2";
    @(negedge clk);
    halt_req = 1; sleep_req = 1;
    @(negedge clk);
    halt_req = 0; sleep_req = 0;
    slow_irq = 4'b1111;
    tick(2);
    check("R2", "sleep priority", int'(cpu_clk_en), 0);
    quiet(); port_irq = 4'b1000;
    @(negedge clk);
    check("R2", "port ends deep stop", int'(resume), 1);
    quiet();
    ack();
    tick(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule